// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block decides when the core of a small 8-bit microcontroller is held in reset, when its CPU and peripheral logic receive clock enables, and when the oscillator may run. A reset pin request is filtered so that only a pin held high for two full machine cycles resets the device. Software asks for a low-power state through two control bits: a light sleep in which the CPU stops while peripherals keep running, and a deep sleep in which the oscillator stops and only a qualified pin reset brings the part back.

The controller is a four-state machine. `MODE_RESET` is entered from power-on and from any state when the pin filter qualifies a request; it leaves through the transition *reset-release* to `MODE_RUN` once the synchronized pin is low. `MODE_RUN` moves by *idle-entry* to `MODE_IDLE` or by *pdown-entry* to `MODE_PDOWN` on a CPU clock-enable cycle with the matching request. `MODE_IDLE` goes back by *irq-wake* to `MODE_RUN` on any interrupt request. `MODE_PDOWN` has no exit other than *pin-reset*, the path into `MODE_RESET` that every state shares. The internal clock is a divide-by-two of the oscillator, so clock enables pulse at most every other oscillator cycle. The internal reset reinitializes special function registers only; there is no RAM clear, and a RAM write block guards memory while a reset request ends idle.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: The pin request is passed through a two-stage synchronizer and qualifies only after 24 consecutive high samples (two machine cycles of 12 oscillator periods); a pin held high for 23 oscillator cycles or fewer never asserts `sfr_rst`, a pin held high for 24 or more always does.
- R2: `sfr_rst` is 1 exactly while the state is `MODE_RESET`; that state is entered from power-on and from any state after qualification, and is left for `MODE_RUN` one cycle after the synchronized pin reads low.
- R3: `cpu_clk_en` and `per_clk_en` are never high on two consecutive oscillator cycles; in `MODE_RUN` each is high on every second cycle.
- R4: In `MODE_RUN`, `idle_req` = 1 on a cycle with `cpu_clk_en` = 1 moves to `MODE_IDLE`; there `cpu_clk_en` stays 0 while `per_clk_en` keeps pulsing every second cycle.
- R5: In `MODE_IDLE`, any set bit of `irq_vec` returns the block to `MODE_RUN` on the next cycle.
- R6: `pd_req` = 1 on a CPU clock-enable cycle in `MODE_RUN` enters `MODE_PDOWN`, where `osc_run_en`, `cpu_clk_en` and `per_clk_en` are all 0 while the pin is low.
- R7: In `MODE_PDOWN`, `irq_vec` has no effect; only a qualified pin reset leaves that state.
- R8: When `idle_req` and `pd_req` are both 1 on the entry cycle, `MODE_PDOWN` is chosen.
- R9: `strobe_hold` = 1 with `strobe_lvl` = 1 in `MODE_IDLE`, `strobe_hold` = 1 with `strobe_lvl` = 0 in `MODE_PDOWN`, and `strobe_hold` = 0 in the other states.
- R10: `ram_wr_blk` is 1 from the cycle the synchronized pin reads high in `MODE_IDLE` until `MODE_RESET` ends, is 1 throughout `MODE_RESET`, and is 0 in `MODE_RUN`; no output clears RAM.
- R11: In `MODE_PDOWN`, `osc_run_en` returns to 1 as soon as the synchronized pin reads high, so the pin filter can run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on initialization, active low, asynchronous |
| rst_pad | input | 1 | Reset pin, active high, asynchronous to clk_osc |
| idle_req | input | 1 | Software request for light sleep |
| pd_req | input | 1 | Software request for deep sleep |
| irq_vec | input | N_IRQ | Enabled interrupt requests |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| sfr_rst | output | 1 | Special function register reset |
| ram_wr_blk | output | 1 | Internal RAM write block |
| strobe_hold | output | 1 | Forces the address-latch and program-read strobes |
| strobe_lvl | output | 1 | Level the forced strobes take |

## Verification
Every cycle the assertions check the divide-by-two spacing of both clock enables, the absence of CPU clocks in light sleep, the oscillator being off in deep sleep while the pin is low, deep sleep holding against interrupts, deep-sleep priority when both requests arrive, that internal reset only starts after a qualified pin, and that the RAM write block covers the whole reset. Only the bench scenarios show the exact 23/24-cycle boundary of the pin filter, interrupt wake from light sleep, the strobe levels in each mode, and recovery from deep sleep through the full reset sequence.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_IDLE  = 2'd2,
        MODE_PDOWN = 2'd3
    } rpc_mode_e;
endpackage

// File: rtl/rpc_pin_filter.sv
module rpc_pin_filter #(
    parameter int OSC_PER_MCYC = 12,
    parameter int RST_MCYC     = 2
) (
    input  logic clk_osc,
    input  logic por_n,
    input  logic rst_pad,
    output logic pin_s,
    output logic qual
);
    localparam int NEED  = OSC_PER_MCYC * RST_MCYC;
    localparam int CNT_W = $clog2(NEED + 1);

    logic             sync1;
    logic [CNT_W-1:0] hi_cnt;

    // two-stage synchronizer for the asynchronous pad
    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) begin
            sync1 <= 1'b0;
            pin_s <= 1'b0;
        end else begin
            sync1 <= rst_pad;
            pin_s <= sync1;
        end
    end

    // run length of consecutive high samples, saturating at NEED
    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) begin
            hi_cnt <= '0;
        end else if (!pin_s) begin
            hi_cnt <= '0;
        end else if (hi_cnt != CNT_W'(NEED)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign qual = (hi_cnt == CNT_W'(NEED));
endmodule

// File: rtl/rpc_clk_div.sv
module rpc_clk_div (
    input  logic clk_osc,
    input  logic por_n,
    output logic phase
);
    // divide-by-two phase: internal clock edge on every second oscillator cycle
    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) phase <= 1'b0;
        else        phase <= ~phase;
    end
endmodule

// File: rtl/rpc_mode_fsm.sv
module rpc_mode_fsm
    import rpc_pkg::*;
#(
    parameter int N_IRQ = 6
) (
    input  logic             clk_osc,
    input  logic             por_n,
    input  logic             phase,
    input  logic             pin_s,
    input  logic             qual,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [N_IRQ-1:0] irq_vec,
    output rpc_mode_e        st_q,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_run_en,
    output logic             sfr_rst,
    output logic             ram_wr_blk,
    output logic             strobe_hold,
    output logic             strobe_lvl
);
    rpc_mode_e st_d;
    logic      cpu_tick;

    assign cpu_tick = phase && (st_q == MODE_RUN);

    // next-state selection
    always_comb begin
        st_d = st_q;
        if (qual) begin
            st_d = MODE_RESET;                       // pin-reset, any state
        end else begin
            unique case (st_q)
                MODE_RESET: if (!pin_s)     st_d = MODE_RUN;   // reset-release
                MODE_RUN: begin
                    if (cpu_tick && pd_req)        st_d = MODE_PDOWN; // pdown-entry
                    else if (cpu_tick && idle_req) st_d = MODE_IDLE;  // idle-entry
                end
                MODE_IDLE:  if (|irq_vec)   st_d = MODE_RUN;   // irq-wake
                MODE_PDOWN: st_d = MODE_PDOWN;
                default:    st_d = MODE_RESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) st_q <= MODE_RESET;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        cpu_clk_en  = 1'b0;
        per_clk_en  = 1'b0;
        osc_run_en  = 1'b1;
        sfr_rst     = 1'b0;
        ram_wr_blk  = 1'b0;
        strobe_hold = 1'b0;
        strobe_lvl  = 1'b0;
        unique case (st_q)
            MODE_RESET: begin
                cpu_clk_en = phase;
                per_clk_en = phase;
                sfr_rst    = 1'b1;
                ram_wr_blk = 1'b1;
            end
            MODE_RUN: begin
                cpu_clk_en = phase;
                per_clk_en = phase;
            end
            MODE_IDLE: begin
                per_clk_en  = phase;
                ram_wr_blk  = pin_s;
                strobe_hold = 1'b1;
                strobe_lvl  = 1'b1;
            end
            MODE_PDOWN: begin
                osc_run_en  = pin_s;
                strobe_hold = 1'b1;
                strobe_lvl  = 1'b0;
            end
            default: begin
                sfr_rst = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int N_IRQ        = 6,
    parameter int OSC_PER_MCYC = 12,
    parameter int RST_MCYC     = 2
) (
    input  logic             clk_osc,
    input  logic             por_n,
    input  logic             rst_pad,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [N_IRQ-1:0] irq_vec,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_run_en,
    output logic             sfr_rst,
    output logic             ram_wr_blk,
    output logic             strobe_hold,
    output logic             strobe_lvl
);
    logic      pin_s;
    logic      qual;
    logic      phase;
    rpc_mode_e st_q;

    rpc_pin_filter #(
        .OSC_PER_MCYC (OSC_PER_MCYC),
        .RST_MCYC     (RST_MCYC)
    ) u_filt (
        .clk_osc (clk_osc),
        .por_n   (por_n),
        .rst_pad (rst_pad),
        .pin_s   (pin_s),
        .qual    (qual)
    );

    rpc_clk_div u_div (
        .clk_osc (clk_osc),
        .por_n   (por_n),
        .phase   (phase)
    );

    rpc_mode_fsm #(
        .N_IRQ (N_IRQ)
    ) u_fsm (
        .clk_osc     (clk_osc),
        .por_n       (por_n),
        .phase       (phase),
        .pin_s       (pin_s),
        .qual        (qual),
        .idle_req    (idle_req),
        .pd_req      (pd_req),
        .irq_vec     (irq_vec),
        .st_q        (st_q),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_run_en  (osc_run_en),
        .sfr_rst     (sfr_rst),
        .ram_wr_blk  (ram_wr_blk),
        .strobe_hold (strobe_hold),
        .strobe_lvl  (strobe_lvl)
    );
endmodule

// File: rtl/rpc_chk.sv
module rpc_chk
    import rpc_pkg::*;
(
    input logic      clk_osc,
    input logic      por_n,
    input logic      pin_s,
    input logic      qual,
    input logic      idle_req,
    input logic      pd_req,
    input rpc_mode_e st_q,
    input logic      cpu_clk_en,
    input logic      per_clk_en,
    input logic      osc_run_en,
    input logic      sfr_rst,
    input logic      ram_wr_blk
);
    // R3
    cpu_div2_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        cpu_clk_en |=> !cpu_clk_en);
    // R3
    per_div2_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        per_clk_en |=> !per_clk_en);
    // R4
    idle_cpu_off_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (st_q == MODE_IDLE) |-> !cpu_clk_en);
    // R6
    pdown_osc_off_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (st_q == MODE_PDOWN && !pin_s) |-> !osc_run_en && !per_clk_en);
    // R7
    pdown_hold_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (st_q == MODE_PDOWN && !qual) |=> (st_q == MODE_PDOWN));
    // R8
    pd_priority_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        (cpu_clk_en && st_q == MODE_RUN && pd_req && idle_req && !qual)
        |=> (st_q == MODE_PDOWN));
    // R1
    rst_needs_qual_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        $rose(sfr_rst) |-> $past(qual));
    // R10
    ram_blk_in_rst_chk: assert property (@(posedge clk_osc) disable iff (!por_n)
        sfr_rst |-> ram_wr_blk);
endmodule

bind rst_pwr_ctrl rpc_chk u_chk (
    .clk_osc    (clk_osc),
    .por_n      (por_n),
    .pin_s      (pin_s),
    .qual       (qual),
    .idle_req   (idle_req),
    .pd_req     (pd_req),
    .st_q       (st_q),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_run_en (osc_run_en),
    .sfr_rst    (sfr_rst),
    .ram_wr_blk (ram_wr_blk)
);

// File: tb/sim_rst_pwr_ctrl.sv
`timescale 1ns/100ps
module sim_rst_pwr_ctrl;
    localparam int N_IRQ = 6;
    localparam int NEED  = 24;

    logic             clk_osc = 1'b0;
    logic             por_n;
    logic             rst_pad;
    logic             idle_req;
    logic             pd_req;
    logic [N_IRQ-1:0] irq_vec;
    logic cpu_clk_en, per_clk_en, osc_run_en, sfr_rst, ram_wr_blk, strobe_hold, strobe_lvl;

    int n_run  = 0;
    int n_fail = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #2.5 clk_osc = ~clk_osc;

    rst_pwr_ctrl #(.N_IRQ(N_IRQ)) u0 (
        .clk_osc, .por_n, .rst_pad, .idle_req, .pd_req, .irq_vec,
        .cpu_clk_en, .per_clk_en, .osc_run_en, .sfr_rst, .ram_wr_blk,
        .strobe_hold, .strobe_lvl
    );

    always @(negedge clk_osc) if (sfr_rst) rst_seen++;

    function automatic bit exp_reset(input int len);
        return len >= NEED;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_osc);
    endtask

    // drive the pad high for len oscillator edges, then let the block settle
    task automatic pin_pulse(input int len);
        rst_seen = 0;
        rst_pad = 1'b1;
        cyc(len);
        rst_pad = 1'b0;
        cyc(8);
    endtask

    task automatic count_en(input int n, output int c_cpu, output int c_per);
        c_cpu = 0; c_per = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            c_cpu += int'(cpu_clk_en);
            c_per += int'(per_clk_en);
        end
    endtask

    initial begin
        int c_cpu, c_per, len;
        void'($urandom(32'h5eed_0042));
        por_n = 1'b0; rst_pad = 1'b0; idle_req = 1'b0; pd_req = 1'b0; irq_vec = '0;
        cyc(2);
        // R2: power-on state is internal reset
        check(sfr_rst == 1'b1, "R2 por", sfr_rst, 1);
        check(ram_wr_blk == 1'b1, "R10 por", ram_wr_blk, 1);
        por_n = 1'b1;
        cyc(3);
        check(sfr_rst == 1'b0, "R2 release", sfr_rst, 0);
        check(strobe_hold == 1'b0, "R9 run", strobe_hold, 0);
        check(ram_wr_blk == 1'b0, "R10 run", ram_wr_blk, 0);

        // R3: alternate-cycle enables in run
        count_en(8, c_cpu, c_per);
        check(c_cpu == 4, "R3 cpu", c_cpu, 4);
        check(c_per == 4, "R3 per", c_per, 4);

        // R1: exact boundary of the pin filter
        pin_pulse(NEED - 1);
        check((rst_seen > 0) == exp_reset(NEED - 1), "R1 short", rst_seen, 0);
        pin_pulse(NEED);
        check((rst_seen > 0) == exp_reset(NEED), "R1 exact", rst_seen, 1);
        pin_pulse(1);
        check((rst_seen > 0) == exp_reset(1), "R1 glitch", rst_seen, 0);
        for (int k = 0; k < 10; k++) begin
            len = 1 + int'($urandom_range(39));
            pin_pulse(len);
            check((rst_seen > 0) == exp_reset(len), "R1 random", (rst_seen > 0), int'(exp_reset(len)));
        end
        // R2: reset lasts while pin high
        pin_pulse(40);
        check(rst_seen >= 40 - NEED - 1 && rst_seen <= 40 - NEED + 3, "R2 length", rst_seen, 40 - NEED + 1);
        check(sfr_rst == 1'b0, "R2 exit", sfr_rst, 0);

        // R4/R9: idle entry
        idle_req = 1'b1; cyc(3); idle_req = 1'b0;
        count_en(6, c_cpu, c_per);
        check(c_cpu == 0, "R4 cpu", c_cpu, 0);
        check(c_per == 3, "R4 per", c_per, 3);
        check(strobe_hold && strobe_lvl, "R9 idle", {strobe_hold, strobe_lvl}, 3);
        // R5: interrupt wake
        irq_vec = N_IRQ'(1) << $urandom_range(N_IRQ - 1);
        cyc(1); irq_vec = '0;
        count_en(6, c_cpu, c_per);
        check(c_cpu == 3, "R5 wake", c_cpu, 3);

        // R10: reset request ends idle
        idle_req = 1'b1; cyc(3); idle_req = 1'b0;
        rst_pad = 1'b1; cyc(4);
        check(ram_wr_blk == 1'b1 && sfr_rst == 1'b0, "R10 idle req", ram_wr_blk, 1);
        cyc(30);
        check(ram_wr_blk == 1'b1 && sfr_rst == 1'b1, "R10 in reset", ram_wr_blk, 1);
        rst_pad = 1'b0; cyc(6);
        check(ram_wr_blk == 1'b0 && cpu_clk_en != per_clk_en == 1'b0, "R10 run", ram_wr_blk, 0);

        // R6/R7/R9: power down, interrupts ignored
        pd_req = 1'b1; cyc(3); pd_req = 1'b0;
        check(osc_run_en == 1'b0, "R6 osc", osc_run_en, 0);
        check(strobe_hold && !strobe_lvl, "R9 pdown", {strobe_hold, strobe_lvl}, 2);
        c_cpu = 0;
        for (int k = 0; k < 40; k++) begin
            irq_vec = N_IRQ'($urandom);
            cyc(1);
            c_cpu += int'(cpu_clk_en) + int'(per_clk_en) + int'(osc_run_en);
        end
        irq_vec = '0;
        check(c_cpu == 0, "R7 irq ignored", c_cpu, 0);
        // R11: pin restarts oscillator, reset exits
        rst_pad = 1'b1; cyc(3);
        check(osc_run_en == 1'b1, "R11 osc", osc_run_en, 1);
        cyc(30); rst_pad = 1'b0; cyc(6);
        count_en(6, c_cpu, c_per);
        check(c_cpu == 3, "R7 reset exit", c_cpu, 3);

        // R8: both requests together
        idle_req = 1'b1; pd_req = 1'b1; cyc(3); idle_req = 1'b0; pd_req = 1'b0;
        check(osc_run_en == 1'b0 && strobe_lvl == 1'b0, "R8 priority", osc_run_en, 0);
        rst_pad = 1'b1; cyc(32); rst_pad = 1'b0; cyc(6);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk_osc);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule